// File: doc/BRIEF.md
# Buffered Serial Transmitter (MSB-first, optional parity)

This block turns bytes written over a simple register-style write port into asynchronous serial frames on one output line. A one-byte holding register sits in front of a separate shift register. Software can therefore load the next byte while the current one is still going out on the line. When the holding register is refilled in time, frames follow one another with no idle bit between them.

Each frame is a low start bit and the data bits, most significant first. An optional parity bit follows when parity is enabled, and then one high stop bit. Every bit lasts exactly one period of an external baud enable pulse, and a new frame starts only on such a pulse. Two status outputs report progress:
- A sticky buffer-empty flag is raised when the held byte moves into the shift register. It serves as the interrupt or DMA request, and it is cleared by a write-one pulse.
- A busy output covers both the holding register and the shift register.

Top module: `sertx_top`

## Requirements
- R1: After reset `ser_out` is 1, `busy` is 0 and `buf_empty` is 0.
- R2: A byte waiting in the holding register while the line is idle is moved into the shift register on the next cycle in which `baud_tick` is 1. From that edge `ser_out` is 0 (start bit) for exactly one tick period.
- R3: The data bits follow the start bit most significant bit first. Each bit lasts exactly one tick period.
- R4: With `par_en`=1 one parity bit follows the last data bit. Its value is the XOR of the data bits XOR `par_odd`: `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity. With `par_en`=0 no parity bit is sent. Both inputs are sampled when the byte enters the shift register.
- R5: Every frame ends with one stop bit at 1 lasting one tick period. With nothing pending, the line then stays at 1.
- R6: `buf_empty` becomes 1 on the edge that moves a byte into the shift register. It stays 1 until a cycle with `clr_empty`=1. If a transfer and a clear fall on the same edge, the flag ends at 1.
- R7: A second write before the pending byte has been transferred replaces it. Only the last byte written is sent, in a single frame.
- R8: `busy` is 1 from the cycle after a write. It returns to 0 after the stop bit of the last frame, once both the holding register and the shift register are empty.
- R9: If a byte is pending when a stop bit ends, the next start bit begins on that same tick. Consecutive frame starts are then exactly (frame length in bits) tick periods apart.
- R10: A write accepted while a frame is shifting does not alter that frame. The new byte is sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| par_en | input | 1 | 1 adds a parity bit to frames |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| clr_empty | input | 1 | Write-one clear of the buffer-empty flag |
| ser_out | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Sticky buffer-empty interrupt/DMA request |
| busy | output | 1 | Holding register or shift register occupied |

## Verification
The hardest case to reach is a clear pulse landing on the very edge that moves a byte into the shift register. That is the only moment when set and clear of the flag collide. The bench generates `baud_tick` from its own cycle counter, so it knows which edge performs the transfer. It writes a byte just after one tick and raises `clr_empty` in exactly the next tick cycle. The overwrite case uses the same alignment to place two writes inside one tick window. The back-to-back case refills the buffer as soon as the flag rises, and then measures the exact distance between start bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
  } par_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R7 / R10: a write always lands, replacing any pending byte
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (full && data == $past(wr_data)));

  // R8: a transfer with no write leaves the holding register empty
  assert_take_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> !full);

endmodule

// File: rtl/sertx_flag.sv
module sertx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R6: a transfer always raises the flag, even against a clear
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R6: the flag is sticky until cleared
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              have_byte,
  input  logic [DATA_W-1:0] byte_in,
  input  par_cfg_t          cfg,
  output logic              take,
  output logic              ser_out,
  output logic              active
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              par_bit;
  logic              par_on;
  logic              ser_q;

  assign take    = tick && have_byte && (state == ST_IDLE || state == ST_STOP);
  assign ser_out = ser_q;
  assign active  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      par_bit <= 1'b0;
      par_on  <= 1'b0;
      ser_q   <= 1'b1;
    end else if (tick) begin
      if (take) begin
        shreg   <= byte_in;
        par_bit <= (^byte_in) ^ cfg.par_odd;
        par_on  <= cfg.par_en;
        ser_q   <= 1'b0;
        state   <= ST_START;
      end else begin
        case (state)
          ST_START: begin
            ser_q  <= shreg[DATA_W-1];
            shreg  <= shreg << 1;
            bitcnt <= LAST_IDX;
            state  <= ST_DATA;
          end
          ST_DATA: begin
            if (bitcnt == '0) begin
              if (par_on) begin
                ser_q <= par_bit;
                state <= ST_PAR;
              end else begin
                ser_q <= 1'b1;
                state <= ST_STOP;
              end
            end else begin
              ser_q  <= shreg[DATA_W-1];
              shreg  <= shreg << 1;
              bitcnt <= bitcnt - 1'b1;
            end
          end
          ST_PAR: begin
            ser_q <= 1'b1;
            state <= ST_STOP;
          end
          default: begin
            ser_q <= 1'b1;
            state <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R5: idle line is high
  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> ser_q);

  // R5: stop bit is high
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> ser_q);

  // R2: start bit is low
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> !ser_q);

  // R9: a pending byte at the end of a stop bit starts at once
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && state == ST_STOP && have_byte) |=> (state == ST_START && !ser_q));

  // R3: the bit state only moves on a tick
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(ser_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_empty,
  output logic              ser_out,
  output logic              buf_empty,
  output logic              busy
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              sh_active;
  par_cfg_t          cfg;

  assign cfg.par_en  = par_en;
  assign cfg.par_odd = par_odd;

  sertx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_shift #(.DATA_W(DATA_W)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .have_byte (hold_full),
    .byte_in   (hold_data),
    .cfg       (cfg),
    .take      (take),
    .ser_out   (ser_out),
    .active    (sh_active)
  );

  sertx_flag flag_i (
    .clk  (clk),
    .rst  (rst),
    .set  (take),
    .clr  (clr_empty),
    .flag (buf_empty)
  );

  assign busy = hold_full | sh_active;

  // R8: busy follows any write
  assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy);

  // R5: a quiet block keeps the line high
  assert_quiet_line_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int WD_LIMIT = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       clr_empty = 1'b0;
  logic       ser_out, buf_empty, busy;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  int rx_data[$];
  int rx_par[$];
  int rx_stop[$];
  int rx_start[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  assign baud_tick = (cyc % DIV) == (DIV - 1);

  sertx_top #(.DATA_W(8)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .clr_empty (clr_empty),
    .ser_out   (ser_out),
    .buf_empty (buf_empty),
    .busy      (busy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // frame decoder, sampling each bit mid-period
  logic [7:0] m_d;
  logic       m_p;
  logic       m_pon;
  int         m_t0;
  always begin
    @(negedge clk);
    if (!rst && ser_out === 1'b0) begin
      m_t0  = cyc;
      m_pon = par_en;
      m_p   = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (DIV) @(negedge clk);
        m_d = {m_d[6:0], ser_out};
      end
      if (m_pon) begin
        repeat (DIV) @(negedge clk);
        m_p = ser_out;
      end
      repeat (DIV) @(negedge clk);
      rx_stop.push_back(int'(ser_out));
      rx_par.push_back(int'(m_p));
      rx_start.push_back(m_t0);
      rx_data.push_back(int'(m_d));
    end
  end

  task automatic wr_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_pulse();
    clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int guard = 0;
    while (rx_data.size() < n && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic wait_tick_negedge();
    @(negedge clk);
    while (!baud_tick) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ser_out === 1'b1, "R1 line after reset", int'(ser_out), 1);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(buf_empty === 1'b0, "R1 flag after reset", int'(buf_empty), 0);
  endtask

  task automatic t_single();
    int n0 = rx_data.size();
    int wc;
    par_en = 1'b0;
    wait_tick_negedge();
    wc = cyc;
    wr_byte(8'hA5);
    chk(busy === 1'b1, "R8 busy after write", int'(busy), 1);
    wait_frames(n0 + 1);
    chk(rx_data.size() == n0 + 1, "R2 frame seen", rx_data.size(), n0 + 1);
    chk(rx_start[n0] - wc <= DIV + 1, "R2 start on next tick", rx_start[n0] - wc, DIV);
    chk(rx_data[n0] == 8'hA5, "R3 data MSB first", rx_data[n0], 8'hA5);
    chk(rx_stop[n0] == 1, "R5 stop bit", rx_stop[n0], 1);
    chk(buf_empty === 1'b1, "R6 flag set and held", int'(buf_empty), 1);
    chk(busy === 1'b1, "R8 busy during stop", int'(busy), 1);
    repeat (DIV) @(negedge clk);
    chk(busy === 1'b0, "R8 busy drops after frame", int'(busy), 0);
    chk(ser_out === 1'b1, "R5 idle high", int'(ser_out), 1);
    chk(buf_empty === 1'b1, "R6 flag sticky", int'(buf_empty), 1);
    clr_pulse();
    chk(buf_empty === 1'b0, "R6 flag cleared", int'(buf_empty), 0);
  endtask

  task automatic t_parity(input logic odd, input logic [7:0] d);
    int n0 = rx_data.size();
    int exp_p = int'((^d) ^ odd);
    par_en = 1'b1; par_odd = odd;
    @(negedge clk);
    wr_byte(d);
    wait_frames(n0 + 1);
    chk(rx_data[n0] == int'(d), "R4 data with parity", rx_data[n0], int'(d));
    chk(rx_par[n0] == exp_p, "R4 parity bit", rx_par[n0], exp_p);
    chk(rx_stop[n0] == 1, "R5 stop after parity", rx_stop[n0], 1);
    repeat (2 * DIV) @(negedge clk);
    par_en = 1'b0;
    clr_pulse();
  endtask

  task automatic t_overwrite();
    int n0 = rx_data.size();
    par_en = 1'b0;
    wait_tick_negedge();
    wr_byte(8'h11);
    wr_byte(8'h22);
    wait_frames(n0 + 1);
    repeat (12 * DIV) @(negedge clk);
    chk(rx_data.size() == n0 + 1, "R7 single frame", rx_data.size(), n0 + 1);
    chk(rx_data[n0] == 8'h22, "R7 last byte wins", rx_data[n0], 8'h22);
    clr_pulse();
  endtask

  task automatic t_back_to_back();
    int n0 = rx_data.size();
    int guard = 0;
    par_en = 1'b0;
    @(negedge clk);
    wr_byte(8'hC3);
    while (!buf_empty && guard < 100) begin @(negedge clk); guard++; end
    clr_pulse();
    wr_byte(8'h3C);
    wait_frames(n0 + 2);
    chk(rx_data[n0] == 8'hC3, "R10 first frame intact", rx_data[n0], 8'hC3);
    chk(rx_data[n0 + 1] == 8'h3C, "R10 second frame data", rx_data[n0 + 1], 8'h3C);
    chk(rx_start[n0 + 1] - rx_start[n0] == 10 * DIV, "R9 no idle gap",
        rx_start[n0 + 1] - rx_start[n0], 10 * DIV);
    repeat (2 * DIV) @(negedge clk);
    clr_pulse();
  endtask

  task automatic t_set_beats_clear();
    int n0 = rx_data.size();
    chk(buf_empty === 1'b0, "R6 flag low before collision", int'(buf_empty), 0);
    wait_tick_negedge();
    wr_byte(8'h96);
    while (!baud_tick) @(negedge clk);
    clr_pulse();
    chk(buf_empty === 1'b1, "R6 set wins over clear", int'(buf_empty), 1);
    wait_frames(n0 + 1);
    chk(rx_data[n0] == 8'h96, "R2 frame after collision", rx_data[n0], 8'h96);
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_parity(1'b0, 8'h5A);
    t_parity(1'b1, 8'h01);
    t_parity(1'b0, 8'h07);
    t_overwrite();
    t_back_to_back();
    t_set_beats_clear();
    repeat (4 * DIV) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule